// File: doc/BRIEF.md
# Signature Check Cache

This block holds one compact decode signature per program trace, keyed by the address of the trace's first instruction. A pipeline uses it to catch faults that arise when a trace is fetched and decoded again. On each lookup it reports whether the trace has been seen before. If it has, it also reports whether the signature stored earlier differs from the one just produced, which indicates a fault. When a lookup misses, the surrounding logic installs the fresh signature through a separate write port, and the block chooses where in the set it goes.

The store is two-way set-associative. The set index is taken from the start address just above the word-offset bits, and the remaining upper bits form the tag. Tags and valid bits sit in registers, so both ports can compare tags in the cycle the request arrives. Signatures sit in one simple dual-port RAM per way. Each set keeps a single recency bit. A lookup hit updates it, and so does a fill. When a fill needs a slot, an empty way is taken first.

A trace whose entry is evicted before the trace runs again is never compared, so a fault in its first signature passes unseen. This is inherent in the scheme. A synchronous reset empties the whole store.

Top module: `sig_check_cache`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `res_valid` is 0. A reset empties every entry, so any lookup presented after a reset, including after earlier fills, reports `res_hit`=0.
- R2: A lookup accepted with `lk_valid`=1 at a clock edge produces exactly one result. `res_valid` is 1 for that one cycle, two edges later, and is 0 at other times when no lookup is pending.
- R3: `res_hit` is 1 exactly when a valid entry in the addressed set holds the tag of `lk_pc`. On a miss `res_mismatch` is 0.
- R4: On a hit, `res_mismatch` is 1 exactly when the stored signature differs from `lk_sig`.
- R5: The set index is `pc[OFS_W +: log2(SETS)]` and the tag is all higher bits. Addresses that differ only in the low `OFS_W` bits reach the same entry. An address with the same index but a different tag misses.
- R6: A write whose address is already present replaces that entry's signature in place and never creates a second copy.
- R7: A write to a set with an empty way fills the empty way, taking way 0 before way 1, and evicts nothing.
- R8: When both ways of a set are valid, a write evicts the least recently used way. A lookup hit marks its way as most recent.
- R9: A fill marks the written way as most recent. After two fills to an empty set and no lookups, a third distinct fill evicts the first.
- R10: A lookup presented in the same cycle as a write sees the contents from before that write. Lookups in later cycles see the written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties the store |
| lk_valid | input | 1 | Lookup request strobe |
| lk_pc | input | PC_W | Trace start address for the lookup |
| lk_sig | input | SIG_W | Signature presented for comparison |
| wr_en | input | 1 | Install request strobe |
| wr_pc | input | PC_W | Trace start address to install |
| wr_sig | input | SIG_W | Signature to install |
| res_valid | output | 1 | Lookup result valid, two cycles after the request |
| res_hit | output | 1 | The looked-up trace was present |
| res_mismatch | output | 1 | Hit with a differing stored signature (fault) |

## Verification
The bench builds the block with four sets, 16-bit addresses and 16-bit signatures. With only four sets, a few fills are enough to reach conflicts between ways, so the test can force victim choice after fills alone, after an intervening hit, and in a set that still has an empty way. The narrow tag and the two offset bits make address aliasing and tag-only differences easy to construct. Same-cycle write and lookup pairs exercise the ordering rule against both an occupied and an unoccupied entry.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int NUM_WAYS = 2;

  typedef logic [NUM_WAYS-1:0] way_vec_t;

  // Empty ways first (way 0 before way 1), otherwise the recency pointer.
  function automatic logic pick_victim(input way_vec_t occupied, input logic lru_way);
    if (!occupied[0]) return 1'b0;
    if (!occupied[1]) return 1'b1;
    return lru_way;
  endfunction
endpackage

// File: rtl/scc_tag_store.sv
module scc_tag_store
  import scc_pkg::*;
#(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output way_vec_t         lk_match,
  output way_vec_t         wr_match,
  output way_vec_t         wr_valid,
  output logic             wr_way
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
      end else if (wr_en && (wr_way == 1'(w))) begin
        vld_q[wr_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) begin
        tag_q[wr_idx] <= wr_tag;
      end
    end

    assign lk_match[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign wr_match[w] = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    assign wr_valid[w] = vld_q[wr_idx];
  end

  always_comb begin
    if (|wr_match) begin
      wr_way = wr_match[1];
    end else begin
      wr_way = pick_victim(wr_valid, lru_q[wr_idx]);
    end
  end

  // The recency bit names the way to evict next; a fill to the same set wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else begin
      if (lk_valid && (|lk_match)) begin
        lru_q[lk_idx] <= ~lk_match[1];
      end
      if (wr_en) begin
        lru_q[wr_idx] <= ~wr_way;
      end
    end
  end
endmodule

// File: rtl/scc_sig_ram.sv
module scc_sig_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Read returns the contents from before a same-cycle write.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/scc_compare.sv
module scc_compare
  import scc_pkg::*;
#(
  parameter int SIG_W = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_valid,
  input  way_vec_t                  lk_match,
  input  logic [SIG_W-1:0]          lk_sig,
  input  logic [NUM_WAYS*SIG_W-1:0] rd_flat,
  output logic                      res_valid,
  output logic                      res_hit,
  output logic                      res_mismatch
);
  logic             s1_valid;
  way_vec_t         s1_match;
  logic [SIG_W-1:0] s1_sig;
  logic [SIG_W-1:0] stored;
  logic             s1_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= lk_valid;
    end
    s1_match <= lk_match;
    s1_sig   <= lk_sig;
  end

  assign stored = s1_match[1] ? rd_flat[2*SIG_W-1:SIG_W] : rd_flat[SIG_W-1:0];
  assign s1_hit = |s1_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_mismatch <= 1'b0;
    end else begin
      res_valid    <= s1_valid;
      res_hit      <= s1_valid && s1_hit;
      res_mismatch <= s1_valid && s1_hit && (stored != s1_sig);
    end
  end
endmodule

// File: rtl/sig_check_cache.sv
module sig_check_cache
  import scc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SIG_W = 64,
  parameter int SETS  = 512,
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [SIG_W-1:0] lk_sig,
  input  logic             wr_en,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [SIG_W-1:0] wr_sig,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_mismatch
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  way_vec_t         lk_match, wr_match, wr_set_valid;
  logic             wr_way;
  logic [NUM_WAYS*SIG_W-1:0] rd_flat;
  logic             unused_ofs;

  assign lk_idx = lk_pc[OFS_W +: IDX_W];
  assign wr_idx = wr_pc[OFS_W +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign wr_tag = wr_pc[PC_W-1 -: TAG_W];
  assign unused_ofs = ^{lk_pc[OFS_W-1:0], wr_pc[OFS_W-1:0]};

  scc_tag_store #(
    .SETS (SETS),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .lk_valid(lk_valid),
    .lk_idx  (lk_idx),
    .lk_tag  (lk_tag),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .lk_match(lk_match),
    .wr_match(wr_match),
    .wr_valid(wr_set_valid),
    .wr_way  (wr_way)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_ram
    scc_sig_ram #(
      .DEPTH(SETS),
      .AW   (IDX_W),
      .DW   (SIG_W)
    ) u_ram (
      .clk  (clk),
      .we   (wr_en && (wr_way == 1'(w))),
      .waddr(wr_idx),
      .wdata(wr_sig),
      .re   (lk_valid),
      .raddr(lk_idx),
      .rdata(rd_flat[w*SIG_W +: SIG_W])
    );
  end

  scc_compare #(
    .SIG_W(SIG_W)
  ) u_cmp (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_match    (lk_match),
    .lk_sig      (lk_sig),
    .rd_flat     (rd_flat),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_mismatch(res_mismatch)
  );
endmodule

// File: rtl/scc_checker.sv
module scc_checker (
  input logic       clk,
  input logic       rst,
  input logic       lk_valid,
  input logic       wr_en,
  input logic       res_valid,
  input logic       res_hit,
  input logic       res_mismatch,
  input logic [1:0] wr_match,
  input logic [1:0] wr_set_valid,
  input logic       wr_way
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);

  // R2
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> ##2 res_valid);

  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(lk_valid, 2));

  // R3
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> !res_mismatch);

  // R6
  single_copy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(wr_match) <= 1));

  // R7
  empty_way0_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_match == 2'b00) && !wr_set_valid[0]) |-> !wr_way);

  // R7
  empty_way1_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_match == 2'b00) && (wr_set_valid == 2'b01)) |-> wr_way);
endmodule

bind sig_check_cache scc_checker i_scc_checker (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .wr_en       (wr_en),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .res_mismatch(res_mismatch),
  .wr_match    (wr_match),
  .wr_set_valid(wr_set_valid),
  .wr_way      (wr_way)
);

// File: tb/test_sig_check_cache.sv
module test_sig_check_cache;
  localparam int PC_W  = 16;
  localparam int SIG_W = 16;
  localparam int SETS  = 4;
  localparam int OFS_W = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0;
  logic [PC_W-1:0]  lk_pc = '0;
  logic [SIG_W-1:0] lk_sig = '0;
  logic             wr_en = 1'b0;
  logic [PC_W-1:0]  wr_pc = '0;
  logic [SIG_W-1:0] wr_sig = '0;
  logic             res_valid, res_hit, res_mismatch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sig_check_cache #(
    .PC_W(PC_W), .SIG_W(SIG_W), .SETS(SETS), .OFS_W(OFS_W)
  ) i_sig_check_cache (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_sig(lk_sig),
    .wr_en(wr_en), .wr_pc(wr_pc), .wr_sig(wr_sig),
    .res_valid(res_valid), .res_hit(res_hit), .res_mismatch(res_mismatch)
  );

  function automatic logic [PC_W-1:0] mk_pc(logic [11:0] tag, logic [1:0] set, logic [1:0] ofs);
    return {tag, set, ofs};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [PC_W-1:0] pc, input logic [SIG_W-1:0] sig);
    @(negedge clk);
    wr_en = 1'b1; wr_pc = pc; wr_sig = sig;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Lookup, then check timing (R2) and the hit/mismatch outcome.
  task automatic do_lookup(input logic [PC_W-1:0] pc, input logic [SIG_W-1:0] sig,
                           input logic exp_hit, input logic exp_mm, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_sig = sig;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid, 1'b0, "R2", "result early");
    @(negedge clk);
    chk(res_valid, 1'b1, "R2", "result at two cycles");
    chk(res_hit, exp_hit, req, "hit");
    chk(res_mismatch, exp_mm, req, "mismatch");
    @(negedge clk);
    chk(res_valid, 1'b0, "R2", "single result");
  endtask

  task automatic t_reset;
    chk(res_valid, 1'b0, "R1", "valid after reset");
    do_lookup(mk_pc(12'h001, 2'd1, 2'd0), 16'h1234, 1'b0, 1'b0, "R1 R3 empty");
  endtask

  task automatic t_hit_and_fault;
    do_write(mk_pc(12'h0A1, 2'd1, 2'd0), 16'h1234);
    do_lookup(mk_pc(12'h0A1, 2'd1, 2'd0), 16'h1234, 1'b1, 1'b0, "R3 R4 match");
    do_lookup(mk_pc(12'h0A1, 2'd1, 2'd0), 16'h1235, 1'b1, 1'b1, "R4 differ");
    do_lookup(mk_pc(12'h0A1, 2'd1, 2'd3), 16'h1234, 1'b1, 1'b0, "R5 offset alias");
    do_lookup(mk_pc(12'h0A2, 2'd1, 2'd0), 16'h1234, 1'b0, 1'b0, "R5 R3 other tag");
    do_lookup(mk_pc(12'h0A1, 2'd2, 2'd0), 16'h1234, 1'b0, 1'b0, "R5 other set");
  endtask

  task automatic t_overwrite;
    do_write(mk_pc(12'h0B1, 2'd2, 2'd0), 16'h1111);
    do_write(mk_pc(12'h0B1, 2'd2, 2'd0), 16'h2222);
    do_lookup(mk_pc(12'h0B1, 2'd2, 2'd0), 16'h1111, 1'b1, 1'b1, "R6 old value gone");
    do_lookup(mk_pc(12'h0B1, 2'd2, 2'd0), 16'h2222, 1'b1, 1'b0, "R6 new value");
  endtask

  task automatic t_empty_first;
    do_write(mk_pc(12'h0C1, 2'd3, 2'd0), 16'h3001);
    do_write(mk_pc(12'h0C2, 2'd3, 2'd0), 16'h3002);
    do_lookup(mk_pc(12'h0C1, 2'd3, 2'd0), 16'h3001, 1'b1, 1'b0, "R7 first kept");
    do_lookup(mk_pc(12'h0C2, 2'd3, 2'd0), 16'h3002, 1'b1, 1'b0, "R7 second kept");
  endtask

  task automatic t_lru_hit;
    do_lookup(mk_pc(12'h0C1, 2'd3, 2'd0), 16'h3001, 1'b1, 1'b0, "R8 touch");
    do_write(mk_pc(12'h0C3, 2'd3, 2'd0), 16'h3003);
    do_lookup(mk_pc(12'h0C2, 2'd3, 2'd0), 16'h3002, 1'b0, 1'b0, "R8 lru evicted");
    do_lookup(mk_pc(12'h0C1, 2'd3, 2'd0), 16'h3001, 1'b1, 1'b0, "R8 recent kept");
    do_lookup(mk_pc(12'h0C3, 2'd3, 2'd0), 16'h3003, 1'b1, 1'b0, "R8 new present");
  endtask

  task automatic t_fill_lru;
    do_write(mk_pc(12'h0D1, 2'd0, 2'd0), 16'h4001);
    do_write(mk_pc(12'h0D2, 2'd0, 2'd0), 16'h4002);
    do_write(mk_pc(12'h0D3, 2'd0, 2'd0), 16'h4003);
    do_lookup(mk_pc(12'h0D1, 2'd0, 2'd0), 16'h4001, 1'b0, 1'b0, "R9 oldest evicted");
    do_lookup(mk_pc(12'h0D2, 2'd0, 2'd0), 16'h4002, 1'b1, 1'b0, "R9 second kept");
    do_lookup(mk_pc(12'h0D3, 2'd0, 2'd0), 16'h4003, 1'b1, 1'b0, "R9 third present");
  endtask

  task automatic same_cycle(input logic [PC_W-1:0] pc, input logic [SIG_W-1:0] new_sig,
                            input logic [SIG_W-1:0] probe, input logic exp_hit,
                            input logic exp_mm, input string what);
    @(negedge clk);
    wr_en = 1'b1; wr_pc = pc; wr_sig = new_sig;
    lk_valid = 1'b1; lk_pc = pc; lk_sig = probe;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    @(negedge clk);
    chk(res_valid, 1'b1, "R10", {what, " valid"});
    chk(res_hit, exp_hit, "R10", {what, " hit"});
    chk(res_mismatch, exp_mm, "R10", {what, " mismatch"});
  endtask

  task automatic t_same_cycle;
    // Set 1 holds tag 0A1 with 1234 and one empty way.
    same_cycle(mk_pc(12'h0A1, 2'd1, 2'd0), 16'h5555, 16'h1234, 1'b1, 1'b0, "old contents");
    do_lookup(mk_pc(12'h0A1, 2'd1, 2'd0), 16'h5555, 1'b1, 1'b0, "R10 later sees write");
    same_cycle(mk_pc(12'h0E1, 2'd1, 2'd0), 16'h6666, 16'h6666, 1'b0, 1'b0, "absent before");
    do_lookup(mk_pc(12'h0E1, 2'd1, 2'd0), 16'h6666, 1'b1, 1'b0, "R10 installed");
  endtask

  task automatic t_reset_clears;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(res_valid, 1'b0, "R1", "valid in reset");
    @(negedge clk); rst = 1'b0;
    chk(res_valid, 1'b0, "R1", "valid after second reset");
    do_lookup(mk_pc(12'h0A1, 2'd1, 2'd0), 16'h5555, 1'b0, 1'b0, "R1 store emptied");
    do_lookup(mk_pc(12'h0C3, 2'd3, 2'd0), 16'h3003, 1'b0, 1'b0, "R1 store emptied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hit_and_fault();
    t_overwrite();
    t_empty_first();
    t_lru_hit();
    t_fill_lru();
    t_same_cycle();
    t_reset_clears();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule